// File: doc/BRIEF.md
# Serial Control Port Command Decoder

This block is the serial control port of a measurement converter. An external host clocks command bytes in on a four-wire serial bus with an active-low select. The block turns those bytes into register writes, register read-backs, conversion-result read-outs and short control strobes. It holds a sixteen-entry, eight-bit register file whose power-up contents are fixed. The three highest entries hold the latest conversion word. The host can read them but cannot write them.

The sampling edge is chosen by a polarity input, so the block works with hosts whose clock idles low or high. The serial state machine returns to its start state in three ways. The first is a system reset. The second is the select line going high. The third applies while select is held low: if the host has sent no clock edge for a set number of data-ready pulses, the next edge begins a new command. Calibration, synchronisation and sleep requests leave the block as one-cycle pulses in the system clock domain. The output driver enable is low whenever read data is not being sent.

Top module: `spi_cmd_if`

## Requirements
- R1: After `rst`, `spi_dout_oe` is low, every strobe is low, and the register file holds 59h at address 0Ah and 55h at addresses 0Bh and 0Ch. All other addresses, including the offset DAC entry at 03h and the result entries, hold 00h.
- R2: The byte 0101_aaaa followed by the byte xxxx_nnnn writes the next nnnn+1 received bytes to the addresses aaaa, aaaa+1, and so on. The address wraps modulo 16.
- R3: The byte 0001_aaaa followed by the byte xxxx_nnnn sends the contents of nnnn+1 registers on `spi_dout`, starting at aaaa, one per byte slot, with the address wrapping modulo 16. Bytes received in those slots are ignored.
- R4: With `spi_pol` low, SCLK idles low, input bits are taken on the falling edge, and output bits change on the rising edge. With `spi_pol` high, both edges are swapped and SCLK idles high.
- R5: Received bytes are taken MSB first. Sent bytes go MSB first when bit 6 of register 02h is 0 and LSB first when it is 1.
- R6: Addresses 0Dh to 0Fh ignore serial writes. When `conv_load` is high, they take `conv_word[23:16]`, `[15:8]` and `[7:0]` respectively.
- R7: Opcode 01h sends registers 0Dh, 0Eh and 0Fh once. Opcode 03h repeats that three-byte group until the byte 0Fh is received, and the transfer ends at that byte's boundary.
- R8: Opcodes F0h, F3h, F4h, FCh and FDh each raise exactly one of `cal_self`, `cal_offset`, `cal_gain`, `sync_pulse` and `sleep_pulse` for exactly one clock cycle. No two strobes are high together.
- R9: Opcode FEh restores every register to its R1 value.
- R10: An opcode outside the set in R2, R3, R7, R8 and R9 has no effect. The next byte is decoded as a new opcode.
- R11: `spi_cs_n` high holds the serial state machine in its start state. A partly received byte is dropped and no strobe is raised.
- R12: If `TO_PULSES` (3) data-ready pulses arrive with no SCLK edge while select is low, the next sampling edge is bit 7 of a new opcode. Fewer pulses leave the command in progress intact.
- R13: `spi_dout_oe` is high only while a read transfer is sending data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low select |
| spi_din | input | 1 | Serial data from the host |
| spi_pol | input | 1 | Clock polarity; selects the sampling edge |
| drdy | input | 1 | One-cycle data-ready pulse, used by the inactivity timeout |
| conv_load | input | 1 | Loads `conv_word` into the result registers |
| conv_word | input | 24 | Latest conversion result |
| spi_dout | output | 1 | Serial data to the host |
| spi_dout_oe | output | 1 | Output driver enable; low means high impedance |
| cal_self | output | 1 | Self-calibration request pulse |
| cal_offset | output | 1 | System offset calibration request pulse |
| cal_gain | output | 1 | System gain calibration request pulse |
| sync_pulse | output | 1 | Synchronisation request pulse |
| sleep_pulse | output | 1 | Sleep request pulse |

## Verification
Random register writes use random start addresses, random lengths up to sixteen and random data, under both clock polarities. Each write is followed by a full sixteen-register read-back. This separates a wrong wrap or address increment from a write that was wrongly accepted at a result register. Because register 02h receives random data, both send bit orders occur, and they are distinguished from a stuck order by fixed checks. Directed sequences cover the following:
- the continuous read-out ended by the stop byte;
- the strobe opcodes and the reset opcode;
- an unknown opcode followed by a read in the same select window;
- a select abort partway through a byte;
- the timeout at exactly three pulses, and no timeout at two pulses.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int unsigned AW    = 4;
  localparam int unsigned DW    = 8;
  localparam int unsigned DEPTH = 1 << AW;

  typedef enum logic [1:0] {
    ST_OP,
    ST_CNT,
    ST_WR,
    ST_TX
  } st_t;

  localparam logic [3:0] PFX_WR     = 4'h5;
  localparam logic [3:0] PFX_RD     = 4'h1;
  localparam logic [7:0] OP_RDATA   = 8'h01;
  localparam logic [7:0] OP_RDATAC  = 8'h03;
  localparam logic [7:0] OP_STOPC   = 8'h0F;
  localparam logic [7:0] OP_CALSELF = 8'hF0;
  localparam logic [7:0] OP_CALOFS  = 8'hF3;
  localparam logic [7:0] OP_CALGAIN = 8'hF4;
  localparam logic [7:0] OP_SYNC    = 8'hFC;
  localparam logic [7:0] OP_SLEEP   = 8'hFD;
  localparam logic [7:0] OP_RESET   = 8'hFE;

  // strobe vector bit positions
  localparam int unsigned SB_SELF  = 0;
  localparam int unsigned SB_OFS   = 1;
  localparam int unsigned SB_GAIN  = 2;
  localparam int unsigned SB_SYNC  = 3;
  localparam int unsigned SB_SLEEP = 4;
  localparam int unsigned NSTRB    = 5;

  function automatic logic [DW-1:0] reg_init(input int a);
    case (a)
      10:      reg_init = 8'h59;
      11, 12:  reg_init = 8'h55;
      default: reg_init = '0;
    endcase
  endfunction

endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int unsigned STAGES    = 2,
  parameter int unsigned TO_PULSES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic din,
  input  logic pol,
  input  logic drdy,
  output logic samp_ev,
  output logic launch_ev,
  output logic din_s,
  output logic cs_hi,
  output logic fresh
);
  localparam int unsigned CW = $clog2(TO_PULSES + 1);

  logic [STAGES-1:0] sck_sr, cs_sr, di_sr;
  logic              sck_prev;
  logic [CW-1:0]     idle_q;
  logic              sck_s, rise, fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_sr   <= {STAGES{pol}};
      cs_sr    <= '1;
      di_sr    <= '0;
      sck_prev <= pol;
    end else begin
      sck_sr   <= {sck_sr[STAGES-2:0], sclk};
      cs_sr    <= {cs_sr[STAGES-2:0], cs_n};
      di_sr    <= {di_sr[STAGES-2:0], din};
      sck_prev <= sck_sr[STAGES-1];
    end
  end

  assign sck_s     = sck_sr[STAGES-1];
  assign rise      = sck_s & ~sck_prev;
  assign fall      = ~sck_s & sck_prev;
  assign samp_ev   = pol ? rise : fall;
  assign launch_ev = pol ? fall : rise;
  assign din_s     = di_sr[STAGES-1];
  assign cs_hi     = cs_sr[STAGES-1];

  // inactivity counter in data-ready pulses
  always_ff @(posedge clk) begin
    if (rst || cs_hi || rise || fall) begin
      idle_q <= '0;
    end else if (drdy && (idle_q != CW'(TO_PULSES))) begin
      idle_q <= idle_q + 1'b1;
    end
  end

  assign fresh = (idle_q == CW'(TO_PULSES));

endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int unsigned RO_BASE   = 13,
  parameter int unsigned CTRL_ADDR = 2,
  localparam int unsigned RO_N     = DEPTH - RO_BASE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               init,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [DW-1:0]      wdata,
  input  logic               ld,
  input  logic [RO_N*DW-1:0] ld_word,
  input  logic [AW-1:0]      raddr,
  output logic [DW-1:0]      rdata,
  output logic [DW-1:0]      ctrl_q
);
  logic [DW-1:0] rf [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (i >= RO_BASE) begin : g_ro
      localparam int unsigned SL = (RO_N - 1 - (i - RO_BASE)) * DW;
      always_ff @(posedge clk) begin
        if (rst || init)  rf[i] <= reg_init(i);
        else if (ld)      rf[i] <= ld_word[SL +: DW];
      end
    end else begin : g_rw
      always_ff @(posedge clk) begin
        if (rst || init)                    rf[i] <= reg_init(i);
        else if (we && (waddr == AW'(i)))   rf[i] <= wdata;
      end
    end
  end

  assign rdata  = rf[raddr];
  assign ctrl_q = rf[CTRL_ADDR];

endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int unsigned RO_BASE = 13,
  localparam int unsigned RO_N   = DEPTH - RO_BASE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             samp_ev,
  input  logic             launch_ev,
  input  logic             din_s,
  input  logic             cs_hi,
  input  logic             fresh,
  input  logic             order_lsb,
  input  logic [DW-1:0]    rdata,
  output logic [AW-1:0]    raddr,
  output logic             we,
  output logic [AW-1:0]    waddr,
  output logic [DW-1:0]    wdata,
  output logic             init,
  output logic [NSTRB-1:0] strb,
  output logic             dout,
  output logic             dout_oe
);
  st_t              st_q, st_b, st_d;
  logic [2:0]       bit_q, bit_b, bit_d;
  logic [DW-2:0]    sh_q, sh_d;
  logic [AW-1:0]    addr_q, addr_d, wa_d;
  logic [AW-1:0]    rem_q, rem_d;
  logic             isrd_q, isrd_d;
  logic             cont_q, cont_b, cont_d;
  logic [DW-1:0]    tx_q, tx_d, wd_d, rx;
  logic             dout_d, we_d, init_d;
  logic [NSTRB-1:0] strb_d;
  logic             byte_done;

  // a timed-out bus restarts from the opcode state at this edge
  assign st_b   = fresh ? ST_OP : st_q;
  assign bit_b  = fresh ? 3'd0 : bit_q;
  assign cont_b = fresh ? 1'b0 : cont_q;

  assign rx        = {sh_q, din_s};
  assign byte_done = samp_ev && (bit_b == 3'd7);

  always_comb begin
    st_d   = st_b;
    bit_d  = bit_b;
    sh_d   = sh_q;
    addr_d = addr_q;
    rem_d  = rem_q;
    isrd_d = isrd_q;
    cont_d = cont_b;
    tx_d   = tx_q;
    dout_d = dout;
    strb_d = '0;
    init_d = 1'b0;
    we_d   = 1'b0;
    wa_d   = addr_q;
    wd_d   = rx;
    raddr  = addr_q;

    if (samp_ev) begin
      sh_d  = {sh_q[DW-3:0], din_s};
      bit_d = bit_b + 3'd1;
    end

    if (launch_ev && (st_b == ST_TX)) begin
      dout_d = order_lsb ? tx_q[bit_b] : tx_q[3'd7 - bit_b];
    end

    if (byte_done) begin
      case (st_b)
        ST_OP: begin
          if (rx[7:4] == PFX_WR) begin
            addr_d = rx[3:0];
            isrd_d = 1'b0;
            st_d   = ST_CNT;
          end else if (rx[7:4] == PFX_RD) begin
            addr_d = rx[3:0];
            isrd_d = 1'b1;
            st_d   = ST_CNT;
          end else begin
            case (rx)
              OP_RDATA, OP_RDATAC: begin
                raddr  = AW'(RO_BASE);
                addr_d = AW'(RO_BASE);
                tx_d   = rdata;
                rem_d  = AW'(RO_N - 1);
                st_d   = ST_TX;
                cont_d = (rx == OP_RDATAC);
              end
              OP_STOPC:   cont_d = 1'b0;
              OP_CALSELF: strb_d[SB_SELF]  = 1'b1;
              OP_CALOFS:  strb_d[SB_OFS]   = 1'b1;
              OP_CALGAIN: strb_d[SB_GAIN]  = 1'b1;
              OP_SYNC:    strb_d[SB_SYNC]  = 1'b1;
              OP_SLEEP:   strb_d[SB_SLEEP] = 1'b1;
              OP_RESET:   init_d = 1'b1;
              default: ;
            endcase
          end
        end
        ST_CNT: begin
          rem_d = rx[3:0];
          if (isrd_q) begin
            tx_d = rdata;
            st_d = ST_TX;
          end else begin
            st_d = ST_WR;
          end
        end
        ST_WR: begin
          we_d   = 1'b1;
          addr_d = addr_q + 1'b1;
          if (rem_q == '0) st_d = ST_OP;
          else             rem_d = rem_q - 1'b1;
        end
        ST_TX: begin
          if (cont_b && (rx == OP_STOPC)) begin
            cont_d = 1'b0;
            st_d   = ST_OP;
          end else if (rem_q == '0) begin
            if (cont_b) begin
              raddr  = AW'(RO_BASE);
              addr_d = AW'(RO_BASE);
              tx_d   = rdata;
              rem_d  = AW'(RO_N - 1);
            end else begin
              st_d = ST_OP;
            end
          end else begin
            raddr  = addr_q + 1'b1;
            addr_d = addr_q + 1'b1;
            tx_d   = rdata;
            rem_d  = rem_q - 1'b1;
          end
        end
        default: st_d = ST_OP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cs_hi) begin
      st_q   <= ST_OP;
      bit_q  <= '0;
      sh_q   <= '0;
      addr_q <= '0;
      rem_q  <= '0;
      isrd_q <= 1'b0;
      cont_q <= 1'b0;
      tx_q   <= '0;
      dout   <= 1'b0;
      strb   <= '0;
      init   <= 1'b0;
      we     <= 1'b0;
      waddr  <= '0;
      wdata  <= '0;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      addr_q <= addr_d;
      rem_q  <= rem_d;
      isrd_q <= isrd_d;
      cont_q <= cont_d;
      tx_q   <= tx_d;
      dout   <= dout_d;
      strb   <= strb_d;
      init   <= init_d;
      we     <= we_d;
      waddr  <= wa_d;
      wdata  <= wd_d;
    end
  end

  assign dout_oe = (st_q == ST_TX);

endmodule

// File: rtl/spi_cmd_if.sv
module spi_cmd_if
  import spi_cmd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TO_PULSES   = 3,
  parameter int unsigned RO_BASE     = 13,
  parameter int unsigned CTRL_ADDR   = 2,
  parameter int unsigned ORDER_BIT   = 6,
  localparam int unsigned RO_N       = DEPTH - RO_BASE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               spi_sclk,
  input  logic               spi_cs_n,
  input  logic               spi_din,
  input  logic               spi_pol,
  input  logic               drdy,
  input  logic               conv_load,
  input  logic [RO_N*DW-1:0] conv_word,
  output logic               spi_dout,
  output logic               spi_dout_oe,
  output logic               cal_self,
  output logic               cal_offset,
  output logic               cal_gain,
  output logic               sync_pulse,
  output logic               sleep_pulse
);
  logic             samp_ev, launch_ev, din_s, cs_hi, fresh;
  logic [AW-1:0]    raddr, waddr;
  logic [DW-1:0]    rdata, wdata, ctrl_q;
  logic             we, init;
  logic [NSTRB-1:0] strb;

  spi_cmd_sync #(
    .STAGES   (SYNC_STAGES),
    .TO_PULSES(TO_PULSES)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .sclk     (spi_sclk),
    .cs_n     (spi_cs_n),
    .din      (spi_din),
    .pol      (spi_pol),
    .drdy     (drdy),
    .samp_ev  (samp_ev),
    .launch_ev(launch_ev),
    .din_s    (din_s),
    .cs_hi    (cs_hi),
    .fresh    (fresh)
  );

  spi_cmd_regs #(
    .RO_BASE  (RO_BASE),
    .CTRL_ADDR(CTRL_ADDR)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .init   (init),
    .we     (we),
    .waddr  (waddr),
    .wdata  (wdata),
    .ld     (conv_load),
    .ld_word(conv_word),
    .raddr  (raddr),
    .rdata  (rdata),
    .ctrl_q (ctrl_q)
  );

  spi_cmd_ctrl #(
    .RO_BASE(RO_BASE)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .samp_ev  (samp_ev),
    .launch_ev(launch_ev),
    .din_s    (din_s),
    .cs_hi    (cs_hi),
    .fresh    (fresh),
    .order_lsb(ctrl_q[ORDER_BIT]),
    .rdata    (rdata),
    .raddr    (raddr),
    .we       (we),
    .waddr    (waddr),
    .wdata    (wdata),
    .init     (init),
    .strb     (strb),
    .dout     (spi_dout),
    .dout_oe  (spi_dout_oe)
  );

  assign cal_self    = strb[SB_SELF];
  assign cal_offset  = strb[SB_OFS];
  assign cal_gain    = strb[SB_GAIN];
  assign sync_pulse  = strb[SB_SYNC];
  assign sleep_pulse = strb[SB_SLEEP];

endmodule

// File: rtl/spi_cmd_if_chk.sv
module spi_cmd_if_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       dout_oe,
  input logic [4:0] strb
);

  AST_OE_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !dout_oe); // R13

  AST_OE_RISE_SEL: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_oe) |-> !cs_n); // R13

  AST_STRB_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb)); // R8

  AST_STRB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (strb != 5'd0) |=> (strb == 5'd0)); // R8

  AST_NO_STRB_DESEL: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> (strb == 5'd0)); // R11

endmodule

bind spi_cmd_if spi_cmd_if_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .cs_n   (spi_cs_n),
  .dout_oe(spi_dout_oe),
  .strb   ({sleep_pulse, sync_pulse, cal_gain, cal_offset, cal_self})
);

// File: tb/spi_cmd_if_bench.sv
module spi_cmd_if_bench;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_din = 1'b0, spi_pol = 1'b0;
  logic drdy = 1'b0, conv_load = 1'b0;
  logic [23:0] conv_word = '0;
  logic spi_dout, spi_dout_oe;
  logic cal_self, cal_offset, cal_gain, sync_pulse, sleep_pulse;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  int n_strb [5];
  logic [7:0] m [16];
  logic [7:0] wbuf [16];

  always #2 clk = ~clk;

  spi_cmd_if u_spi_cmd_if (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_din(spi_din), .spi_pol(spi_pol), .drdy(drdy),
    .conv_load(conv_load), .conv_word(conv_word),
    .spi_dout(spi_dout), .spi_dout_oe(spi_dout_oe),
    .cal_self(cal_self), .cal_offset(cal_offset), .cal_gain(cal_gain),
    .sync_pulse(sync_pulse), .sleep_pulse(sleep_pulse)
  );

  always @(posedge clk) begin
    if (!rst) begin
      if (cal_self)    n_strb[0] <= n_strb[0] + 1;
      if (cal_offset)  n_strb[1] <= n_strb[1] + 1;
      if (cal_gain)    n_strb[2] <= n_strb[2] + 1;
      if (sync_pulse)  n_strb[3] <= n_strb[3] + 1;
      if (sleep_pulse) n_strb[4] <= n_strb[4] + 1;
    end
  end

  function automatic logic [7:0] init_val(input int a);
    return (a == 10) ? 8'h59 : ((a == 11 || a == 12) ? 8'h55 : 8'h00);
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_init();
    for (int a = 0; a < 16; a++) m[a] = init_val(a);
  endtask

  task automatic clk_bit(input logic b, output logic o, output logic oe);
    spi_din = b;
    tick(H);
    spi_sclk = ~spi_pol;
    tick(H);
    o  = spi_dout;
    oe = spi_dout_oe;
    spi_sclk = spi_pol;
    tick(3);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rxb, output logic oe_all);
    logic o, oe;
    oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(tx[i], o, oe);
      rxb[i] = o;
      oe_all &= oe;
    end
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] r;
    logic oe;
    xfer(tx, r, oe);
  endtask

  task automatic cs_begin();
    spi_sclk = spi_pol;
    spi_cs_n = 1'b0;
    tick(4);
  endtask

  task automatic cs_end();
    tick(H);
    spi_cs_n = 1'b1;
    tick(8);
  endtask

  // expected value of the next byte slot of a read, in arrival order
  function automatic logic [8:0] exp_slot(input int a);
    logic [7:0] v;
    v = m[a & 15];
    return {1'b1, (m[2][6] ? rev8(v) : v)};
  endfunction

  // read body: command bytes already aligned, select already low
  task automatic rd_body(input logic [3:0] start, input int n, input string req);
    logic [7:0] r;
    logic oe;
    send({4'h1, start});
    send({4'h0, 4'(n - 1)});
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, r, oe);
      chk(req, {23'd0, oe, r}, {23'd0, exp_slot(start + k)});
    end
  endtask

  task automatic rd_check(input logic [3:0] start, input int n, input string req);
    cs_begin();
    rd_body(start, n, req);
    cs_end();
  endtask

  task automatic wr_regs(input logic [3:0] start, input int n);
    cs_begin();
    send({4'h5, start});
    send({4'hA, 4'(n - 1)});
    for (int k = 0; k < n; k++) begin
      send(wbuf[k]);
      if (((start + k) & 15) < 13) m[(start + k) & 15] = wbuf[k];
    end
    cs_end();
  endtask

  task automatic pulse_drdy();
    drdy = 1'b1;
    tick(1);
    drdy = 1'b0;
    tick(3);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic oe;
    logic b;
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 5; i++) n_strb[i] = 0;
    model_init();
    tick(6);
    rst = 1'b0;
    tick(4);

    // R1: reset state
    chk("R1 oe", {31'd0, spi_dout_oe}, 32'd0);
    chk("R1 strobes", {27'd0, cal_self, cal_offset, cal_gain, sync_pulse, sleep_pulse}, 32'd0);
    rd_check(4'h0, 16, "R1 reset values");

    // R2/R4/R5/R6: random writes, random polarity, full read-back
    for (int it = 0; it < 8; it++) begin
      logic [3:0] st;
      int n;
      spi_pol = 1'($urandom % 2);
      spi_sclk = spi_pol;
      tick(4);
      st = 4'($urandom % 16);
      n = 1 + ($urandom % 16);
      for (int k = 0; k < 16; k++) wbuf[k] = 8'($urandom);
      wr_regs(st, n);
      rd_check(4'h0, 16, spi_pol ? "R2 R4 pol1 readback" : "R2 pol0 readback");
    end

    // R5: directed bit order both ways
    spi_pol = 1'b0; spi_sclk = 1'b0; tick(4);
    wbuf[0] = 8'h40; wr_regs(4'h2, 1);
    rd_check(4'h0, 4, "R5 lsb first");
    wbuf[0] = 8'h00; wr_regs(4'h2, 1);
    rd_check(4'h0, 4, "R5 msb first");

    // R3: wrapping read from 0Eh
    rd_check(4'hE, 5, "R3 wrap read");

    // R6: result registers ignore writes, load from conversion word
    conv_word = 24'hA1B2C3; conv_load = 1'b1; tick(1); conv_load = 1'b0; tick(2);
    m[13] = 8'hA1; m[14] = 8'hB2; m[15] = 8'hC3;
    for (int k = 0; k < 3; k++) wbuf[k] = 8'hFF;
    wr_regs(4'hD, 3);
    rd_check(4'hD, 3, "R6 read-only");

    // R7: single data read-out
    cs_begin();
    send(8'h01);
    for (int k = 0; k < 3; k++) begin
      xfer(8'h00, r, oe);
      chk("R7 rdata", {23'd0, oe, r}, {23'd0, exp_slot(13 + k)});
    end
    tick(H);
    chk("R7 R13 oe after rdata", {31'd0, spi_dout_oe}, 32'd0);
    cs_end();

    // R7: continuous read-out ended by stop byte
    spi_pol = 1'b1; spi_sclk = 1'b1; tick(4);
    cs_begin();
    send(8'h03);
    for (int k = 0; k < 6; k++) begin
      xfer((k == 5) ? 8'h0F : 8'h00, r, oe);
      chk("R7 continuous", {23'd0, oe, r}, {23'd0, exp_slot(13 + (k % 3))});
    end
    tick(H);
    chk("R7 R13 oe after stop", {31'd0, spi_dout_oe}, 32'd0);
    cs_end();
    spi_pol = 1'b0; spi_sclk = 1'b0; tick(4);

    // R8: strobes
    chk("R8 no strobes yet", 32'(n_strb[0] + n_strb[1] + n_strb[2] + n_strb[3] + n_strb[4]), 32'd0);
    cs_begin();
    send(8'hF0); send(8'hF3); send(8'hF4); send(8'hFC); send(8'hFD);
    cs_end();
    for (int i = 0; i < 5; i++) chk("R8 strobe count", 32'(n_strb[i]), 32'd1);

    // R10: unknown opcodes then a read in the same select window
    cs_begin();
    send(8'h77); send(8'hA5); send(8'h2C);
    rd_body(4'h0, 16, "R10 after unknown");
    cs_end();
    chk("R10 no strobes", 32'(n_strb[0] + n_strb[1] + n_strb[2] + n_strb[3] + n_strb[4]), 32'd5);

    // R9: reset opcode
    cs_begin(); send(8'hFE); cs_end();
    model_init();
    rd_check(4'h0, 16, "R9 reset opcode");

    // R11: select abort mid-byte
    cs_begin();
    clk_bit(1'b1, b, oe); clk_bit(1'b1, b, oe); clk_bit(1'b1, b, oe);
    cs_end();
    rd_check(4'hA, 3, "R11 abort");

    // R12: timeout after three pulses
    cs_begin();
    clk_bit(1'b1, b, oe); clk_bit(1'b1, b, oe); clk_bit(1'b1, b, oe);
    pulse_drdy(); pulse_drdy(); pulse_drdy();
    rd_body(4'hA, 3, "R12 timeout restart");
    cs_end();

    // R12: two pulses leave the byte in progress intact (0x10 split)
    cs_begin();
    clk_bit(1'b0, b, oe); clk_bit(1'b0, b, oe); clk_bit(1'b0, b, oe); clk_bit(1'b1, b, oe);
    pulse_drdy(); pulse_drdy();
    for (int i = 0; i < 4; i++) clk_bit(1'b0, b, oe);
    send(8'h02);
    for (int k = 0; k < 3; k++) begin
      xfer(8'h00, r, oe);
      chk("R12 no timeout", {23'd0, oe, r}, {23'd0, exp_slot(k)});
    end
    cs_end();

    // R13: idle driver enable
    chk("R13 oe idle", {31'd0, spi_dout_oe}, 32'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule